// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial slave that owns a small bank of configuration bytes and exports them in parallel to the rest of the chip. A host writes the bank with one block transfer: the device address, two header bytes, then data bytes that fill the bank from the lowest byte upward. The first header byte stands in for a command code and the second for a length. Both are acknowledged and both are thrown away. The host may end the transfer with a STOP after any whole byte. Bytes that were not reached keep their previous values.

A read transfer returns a length byte equal to the bank size, followed by every bank byte from the lowest upward. The bus lines are sampled by a synchronizer running on a system clock at least ten times the serial bit rate. START and STOP are recognised from those samples. The slave never drives SCL. It drives SDA as an open-drain output: `sda_o` is held at zero and `sda_oe` pulls the line low.

Top module: `i2c_cfg_slave`

## Requirements
- R1: Address byte 0xD2 (7-bit address 0x69, R/W bit 0) is acknowledged and begins a write. Address byte 0xD3 is acknowledged and begins a read. Any other address byte is not acknowledged, and every later byte is ignored (not acknowledged) until the next START.
- R2: In a write, the two bytes after the address are acknowledged and change no register.
- R3: Write data bytes are stored in order: the first data byte goes to byte 0 (`cfg_o[7:0]`), the next to byte 1 (`cfg_o[15:8]`), and so on. Every transfer starts again at byte 0.
- R4: A write that ends after k complete data bytes (k < 6) updates bytes 0 to k-1 and leaves the others unchanged.
- R5: Data bytes beyond the sixth are acknowledged and discarded.
- R6: A read returns the byte count 6, then bytes 0 to 5. Each byte is sent MSB first and changes on the falling edge of SCL.
- R7: When the host does not acknowledge a byte it has read, the slave releases SDA and sends nothing more until the next START. Bits clocked after that read as 1.
- R8: After reset, byte 0 is 0x00, bytes 1 to 5 are 0xFF, and SDA is released.
- R9: A STOP (SDA rising while SCL is high) returns the slave to idle with SDA released. A byte cut off by a STOP is not stored.
- R10: The slave changes `sda_oe` only while SCL is low. Every received byte is acknowledged by pulling SDA low for the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_o | output | 1 | Data level driven when enabled (always 0) |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| cfg_o | output | 48 | Register bank; byte k at bits 8k+7..8k |

## Verification
The assertions run on every cycle. They check the following: SDA drive changes only while the synchronized SCL is low; every acknowledge slot drives the line; a STOP always releases SDA; a foreign address or a host NACK sends the controller idle on the next cycle; and register write strobes occur only in write transfers and stay inside the bank. Some behaviour only the directed scenarios can show, because it depends on whole transfers and on the values carried. That includes the order in which data bytes land, headers and excess bytes leaving the bank untouched, partial writes, the length byte and bit order returned on reads, and the line reading as 1 after a NACK.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

   typedef enum logic [2:0] {
      LINK_IDLE,     // waiting for START
      LINK_RX,       // shifting in a byte
      LINK_RX_WAIT,  // byte complete, waiting for SCL low to acknowledge
      LINK_RX_ACK,   // pulling SDA low for the acknowledge clock
      LINK_TX,       // shifting out a byte
      LINK_TX_END,   // last bit sent, waiting to release for host acknowledge
      LINK_TX_ACK,   // sampling host acknowledge
      LINK_TX_NEXT   // acknowledged, waiting for SCL low to load next byte
   } link_state_t;

   localparam logic [7:0] IDLE_BYTE = 8'hFF;

endpackage

// File: rtl/i2c_cfg_sync.sv
module i2c_cfg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);

   initial begin : param_check
      assert (STAGES >= 2 && STAGES <= 8)
         else $fatal(1, "i2c_cfg_sync: STAGES must be within 2..8");
   end

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
         last_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], line_i};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign level_o = chain_q[STAGES-1];
   assign rise_o  = chain_q[STAGES-1] & ~last_q;
   assign fall_o  = ~chain_q[STAGES-1] & last_q;

endmodule

// File: rtl/i2c_cfg_regs.sv
module i2c_cfg_regs #(
   parameter int              NUM_REGS = 6,
   parameter logic [8*NUM_REGS-1:0] DEFAULTS = '0,
   localparam int             REG_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [REG_W-1:0]      wr_idx,
   input  logic [7:0]            wr_data,
   input  logic [REG_W-1:0]      rd_idx,
   output logic [7:0]            rd_data,
   output logic [8*NUM_REGS-1:0] regs_o
);

   initial begin : param_check
      assert (NUM_REGS >= 1 && NUM_REGS <= 64)
         else $fatal(1, "i2c_cfg_regs: NUM_REGS must be within 1..64");
   end

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_byte
      logic [7:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            byte_q <= DEFAULTS[8*g +: 8];
         else if (wr_en && wr_idx == REG_W'(g))
            byte_q <= wr_data;
      end
      assign regs_o[8*g +: 8] = byte_q;
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_REGS; i++)
         if (rd_idx == REG_W'(i)) rd_data = regs_o[8*i +: 8];
   end

   // R5: strobes never address a byte outside the bank
   assert_wr_in_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_idx) < NUM_REGS));

endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
   import i2c_cfg_pkg::*;
#(
   parameter int                    NUM_REGS    = 6,
   parameter logic [6:0]            DEV_ADDR    = 7'h69,
   parameter int                    SYNC_STAGES = 2,
   parameter int                    HDR_BYTES   = 2,
   parameter logic [8*NUM_REGS-1:0] DEFAULTS    = {{(NUM_REGS-1){8'hFF}}, 8'h00}
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   output logic                  sda_o,
   output logic                  sda_oe,
   output logic [8*NUM_REGS-1:0] cfg_o
);

   localparam int REG_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
   localparam int IDX_W = $clog2(NUM_REGS + HDR_BYTES + 2);
   localparam logic [IDX_W-1:0] FIRST_SLOT = IDX_W'(HDR_BYTES);
   localparam logic [IDX_W-1:0] LAST_SLOT  = IDX_W'(HDR_BYTES + NUM_REGS - 1);
   localparam logic [IDX_W-1:0] LAST_READ  = IDX_W'(NUM_REGS);
   localparam logic [IDX_W-1:0] IDX_MAX    = '1;
   localparam logic [7:0]       COUNT_BYTE = 8'(NUM_REGS);

   initial begin : param_check
      assert (HDR_BYTES >= 0 && HDR_BYTES <= 4)
         else $fatal(1, "i2c_cfg_slave: HDR_BYTES must be within 0..4");
      assert (NUM_REGS >= 1 && NUM_REGS <= 64)
         else $fatal(1, "i2c_cfg_slave: NUM_REGS must be within 1..64");
   end

   // bus sampling
   logic scl_s, scl_rise, scl_fall;
   logic sda_s, sda_rise, sda_fall;

   i2c_cfg_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .line_i(scl_i),
      .level_o(scl_s), .rise_o(scl_rise), .fall_o(scl_fall));

   i2c_cfg_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .line_i(sda_i),
      .level_o(sda_s), .rise_o(sda_rise), .fall_o(sda_fall));

   logic start_det, stop_det;
   assign start_det = scl_s & sda_fall;
   assign stop_det  = scl_s & sda_rise;

   // controller state
   link_state_t        state_q;
   logic [2:0]         bit_cnt_q;
   logic [7:0]         rx_sh_q;
   logic [7:0]         tx_sh_q;
   logic [IDX_W-1:0]   byte_idx_q;
   logic               in_addr_q;
   logic               is_read_q;
   logic               sda_oe_q;
   logic               wr_en_q;
   logic [REG_W-1:0]   wr_idx_q;
   logic [7:0]         wr_data_q;

   logic [REG_W-1:0]   rd_idx;
   logic [7:0]         rd_data;
   logic [7:0]         tx_byte;
   logic               data_slot;
   logic [IDX_W-1:0]   idx_inc;

   assign data_slot = (byte_idx_q >= FIRST_SLOT) && (byte_idx_q <= LAST_SLOT);
   assign idx_inc   = (byte_idx_q == IDX_MAX) ? byte_idx_q : byte_idx_q + 1'b1;
   assign rd_idx    = REG_W'(byte_idx_q - 1'b1);

   always_comb begin
      if (byte_idx_q == '0)
         tx_byte = COUNT_BYTE;
      else if (byte_idx_q <= LAST_READ)
         tx_byte = rd_data;
      else
         tx_byte = IDLE_BYTE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= LINK_IDLE;
         bit_cnt_q  <= '0;
         rx_sh_q    <= '0;
         tx_sh_q    <= '1;
         byte_idx_q <= '0;
         in_addr_q  <= 1'b0;
         is_read_q  <= 1'b0;
         sda_oe_q   <= 1'b0;
         wr_en_q    <= 1'b0;
         wr_idx_q   <= '0;
         wr_data_q  <= '0;
      end else begin
         wr_en_q <= 1'b0;
         if (start_det) begin
            state_q    <= LINK_RX;
            in_addr_q  <= 1'b1;
            is_read_q  <= 1'b0;
            bit_cnt_q  <= '0;
            byte_idx_q <= '0;
            sda_oe_q   <= 1'b0;
         end else if (stop_det) begin
            state_q   <= LINK_IDLE;
            in_addr_q <= 1'b0;
            sda_oe_q  <= 1'b0;
         end else begin
            unique case (state_q)
               LINK_IDLE: ;
               LINK_RX: if (scl_rise) begin
                  rx_sh_q   <= {rx_sh_q[6:0], sda_s};
                  bit_cnt_q <= bit_cnt_q + 1'b1;
                  if (bit_cnt_q == 3'd7) state_q <= LINK_RX_WAIT;
               end
               LINK_RX_WAIT: if (scl_fall) begin
                  if (in_addr_q) begin
                     in_addr_q <= 1'b0;
                     if (rx_sh_q[7:1] == DEV_ADDR) begin
                        is_read_q <= rx_sh_q[0];
                        sda_oe_q  <= 1'b1;
                        state_q   <= LINK_RX_ACK;
                     end else begin
                        state_q <= LINK_IDLE;
                     end
                  end else begin
                     sda_oe_q   <= 1'b1;
                     state_q    <= LINK_RX_ACK;
                     byte_idx_q <= idx_inc;
                     if (data_slot) begin
                        wr_en_q   <= 1'b1;
                        wr_idx_q  <= REG_W'(byte_idx_q - FIRST_SLOT);
                        wr_data_q <= rx_sh_q;
                     end
                  end
               end
               LINK_RX_ACK: if (scl_fall) begin
                  bit_cnt_q <= '0;
                  if (is_read_q) begin
                     sda_oe_q   <= ~tx_byte[7];
                     tx_sh_q    <= {tx_byte[6:0], 1'b1};
                     byte_idx_q <= idx_inc;
                     state_q    <= LINK_TX;
                  end else begin
                     sda_oe_q <= 1'b0;
                     state_q  <= LINK_RX;
                  end
               end
               LINK_TX: begin
                  if (scl_rise) begin
                     bit_cnt_q <= bit_cnt_q + 1'b1;
                     if (bit_cnt_q == 3'd7) state_q <= LINK_TX_END;
                  end else if (scl_fall) begin
                     sda_oe_q <= ~tx_sh_q[7];
                     tx_sh_q  <= {tx_sh_q[6:0], 1'b1};
                  end
               end
               LINK_TX_END: if (scl_fall) begin
                  sda_oe_q <= 1'b0;
                  state_q  <= LINK_TX_ACK;
               end
               LINK_TX_ACK: if (scl_rise)
                  state_q <= sda_s ? LINK_IDLE : LINK_TX_NEXT;
               LINK_TX_NEXT: if (scl_fall) begin
                  bit_cnt_q  <= '0;
                  sda_oe_q   <= ~tx_byte[7];
                  tx_sh_q    <= {tx_byte[6:0], 1'b1};
                  byte_idx_q <= idx_inc;
                  state_q    <= LINK_TX;
               end
               default: state_q <= LINK_IDLE;
            endcase
         end
      end
   end

   i2c_cfg_regs #(.NUM_REGS(NUM_REGS), .DEFAULTS(DEFAULTS)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en_q), .wr_idx(wr_idx_q), .wr_data(wr_data_q),
      .rd_idx(rd_idx), .rd_data(rd_data), .regs_o(cfg_o));

   assign sda_o  = 1'b0;
   assign sda_oe = sda_oe_q;

   // R1: a foreign address drops the controller to idle without acknowledge
   assert_foreign_addr_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LINK_RX_WAIT && in_addr_q && scl_fall && !start_det && !stop_det
       && rx_sh_q[7:1] != DEV_ADDR) |=> (state_q == LINK_IDLE && !sda_oe));

   // R10: acknowledge slot always pulls the line low
   assert_ack_slot_driven_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LINK_RX_ACK) |-> sda_oe);

   // R10: drive changes only while SCL is low
   assert_drive_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !$past(scl_s));

   // R3: register strobes belong to write transfers only
   assert_write_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_q |-> !is_read_q);

   // R7: host NACK ends the read
   assert_nack_ends_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LINK_TX_ACK && scl_rise && sda_s && !start_det && !stop_det)
      |=> (state_q == LINK_IDLE && !sda_oe));

   // R9: STOP releases the line
   assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_det && !start_det) |=> !sda_oe);

endmodule

// File: tb/i2c_cfg_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_cfg_slave_tb_top;

   localparam int Q = 10;          // system clocks per SCL quarter period
   localparam int NREG = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic sda_o, sda_oe;
   logic [8*NREG-1:0] cfg_o;
   wire  sda_bus = m_sda & ~(sda_oe & ~sda_o);

   always #2 clk = ~clk;           // 250 MHz

   i2c_cfg_slave dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
      .sda_o(sda_o), .sda_oe(sda_oe), .cfg_o(cfg_o));

   int n_tests = 0;
   int n_fail  = 0;
   int r10_viol = 0;
   logic [7:0] exp_regs [NREG];
   logic [7:0] wbuf [16];

   task automatic check(input string req, input string what, input logic [47:0] got, input logic [47:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   // R10 monitor: slave drive must not change while SCL is high
   logic prev_oe = 1'b0;
   always @(negedge clk) begin
      if (rst_n && sda_oe !== prev_oe && m_scl) r10_viol++;
      prev_oe <= sda_oe;
   end

   task automatic wait_q;
      repeat (Q) @(posedge clk);
      #1;
   endtask

   task automatic bus_start;
      m_sda = 1'b1; wait_q;
      m_scl = 1'b1; wait_q;
      m_sda = 1'b0; wait_q;
      m_scl = 1'b0;
   endtask

   task automatic bus_stop;
      wait_q; m_sda = 1'b0;
      wait_q; m_scl = 1'b1;
      wait_q; m_sda = 1'b1;
      wait_q;
   endtask

   task automatic clock_bit(input logic b, output logic s);
      wait_q; m_sda = b;
      wait_q; m_scl = 1'b1;
      wait_q; s = sda_bus;
      wait_q; m_scl = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) clock_bit(v[i], s);
      clock_bit(1'b1, s);
      ack = ~s;
   endtask

   task automatic recv_byte(input logic host_ack, output logic [7:0] v);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         clock_bit(1'b1, s);
         v[i] = s;
      end
      clock_bit(~host_ack, s);
   endtask

   function automatic logic [47:0] exp_flat();
      logic [47:0] f;
      for (int i = 0; i < NREG; i++) f[8*i +: 8] = exp_regs[i];
      return f;
   endfunction

   // write: address, two headers, n data bytes from wbuf
   task automatic do_write(input string req, input int n);
      logic a;
      bus_start;
      send_byte(8'hD2, a);  check("R1", "write address ack", a, 1'b1);
      send_byte(8'h5A, a);  check("R2", "command byte ack", a, 1'b1);
      send_byte(8'hC3, a);  check("R2", "count byte ack", a, 1'b1);
      for (int i = 0; i < n; i++) begin
         send_byte(wbuf[i], a);
         check(req, "data byte ack", a, 1'b1);
         if (i < NREG) exp_regs[i] = wbuf[i];
      end
      bus_stop;
      check(req, "bank after write", cfg_o, exp_flat());
   endtask

   task automatic t_reset;
      check("R8", "bank after reset", cfg_o, 48'hFFFF_FFFF_FF00);
      check("R8", "SDA released after reset", sda_oe, 1'b0);
   endtask

   task automatic t_full_write;
      for (int i = 0; i < NREG; i++) wbuf[i] = 8'h10 + 8'(i * 17);
      do_write("R3", NREG);
   endtask

   task automatic t_headers_only;
      do_write("R2", 0);
   endtask

   task automatic t_partial;
      wbuf[0] = 8'hA5; wbuf[1] = 8'h3C;
      do_write("R4", 2);
   endtask

   task automatic t_overflow;
      for (int i = 0; i < 9; i++) wbuf[i] = 8'hE0 + 8'(i);
      do_write("R5", 9);
   endtask

   task automatic t_read_all;
      logic a;
      logic [7:0] v;
      bus_start;
      send_byte(8'hD3, a); check("R1", "read address ack", a, 1'b1);
      recv_byte(1'b1, v);  check("R6", "byte count", v, 8'd6);
      for (int i = 0; i < NREG; i++) begin
         recv_byte(i != NREG-1, v);
         check("R6", "read data byte", v, exp_regs[i]);
      end
      wait_q;
      check("R7", "released after final NACK", sda_oe, 1'b0);
      bus_stop;
   endtask

   task automatic t_read_nack;
      logic a;
      logic [7:0] v;
      bus_start;
      send_byte(8'hD3, a);
      recv_byte(1'b0, v);  check("R6", "count before NACK", v, 8'd6);
      wait_q;
      check("R7", "released after NACK", sda_oe, 1'b0);
      recv_byte(1'b0, v);  check("R7", "bits after NACK read high", v, 8'hFF);
      bus_stop;
   endtask

   task automatic t_bad_addr;
      logic a;
      bus_start;
      send_byte(8'hA0, a); check("R1", "foreign address NACK", a, 1'b0);
      send_byte(8'hD2, a); check("R1", "ignored until START", a, 1'b0);
      send_byte(8'h77, a); check("R1", "still ignored", a, 1'b0);
      bus_stop;
      check("R1", "bank untouched by foreign address", cfg_o, exp_flat());
   endtask

   task automatic t_stop_midbyte;
      logic a, s;
      bus_start;
      send_byte(8'hD2, a);
      send_byte(8'h00, a);
      send_byte(8'h00, a);
      send_byte(8'h6E, a); exp_regs[0] = 8'h6E;
      for (int i = 0; i < 4; i++) clock_bit(1'b0, s);
      bus_stop;
      check("R9", "cut byte not stored", cfg_o, exp_flat());
      check("R9", "released after STOP", sda_oe, 1'b0);
      wbuf[0] = 8'h11;
      do_write("R3", 1);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < NREG; i++) exp_regs[i] = (i == 0) ? 8'h00 : 8'hFF;
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (5) @(posedge clk);
      #1;
      t_reset;
      t_headers_only;
      t_full_write;
      t_read_all;
      t_partial;
      t_overflow;
      t_read_all;
      t_read_nack;
      t_bad_addr;
      t_stop_midbyte;
      t_read_all;
      check("R10", "SDA drive changes while SCL high", 48'(r10_viol), 48'd0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule